// File: doc/BRIEF.md
# JTAG Alternating Address/Data Debug Register

This block is one data-register path behind a JTAG TAP. While its instruction is selected, a single 34-bit scan chain reaches a bank of internal debug registers over a simple request/acknowledge bus. The chain plays two roles in turn. In the address phase, a scan carries a 7-bit register index and a direction bit. In the data phase, a scan carries the 32-bit register value: it is written in for a write and scanned out for a read.

Every capture puts two status bits at the low end of the chain, so they are the first bits out on TDO: bit 0 is busy and bit 1 is error. A debugger reads these bits to decide whether the scan it just made counted. The phase flips only after a scan whose captured busy bit was clear. A scan that saw busy set is simply repeated. The TAP state machine and the instruction register sit outside the block. They supply the capture, shift and update strobes and a select flag. The whole block runs on TCK.

Top module: `jtag_alt_dr`

## Requirements
- R1: After a synchronous reset, the block is in the address phase, with bus_req low, busy and error clear, and tdo low.
- R2: While sel and shift_dr are high, each rising TCK edge moves the 34-bit chain one place toward TDO, with tdi entering at bit 33. tdo presents chain bit 0 and changes only on the falling edge of TCK.
- R3: A rising edge with sel and cap_dr high loads the chain with busy in bit 0, error in bit 1 and the held read data in bits 33:2.
- R4: In the address phase, an update takes the register index from chain bits 32:26 and the direction from bit 33 (1 = read, 0 = write). A scan of only 8 bits is therefore enough, and a 34-bit scan whose last 8 bits carry the field gives the same result.
- R5: An accepted address-phase update with direction 1 raises bus_req with bus_rd high and bus_idx set to the scanned index.
- R6: An accepted data-phase update that follows a write address raises bus_req with bus_rd low, the stored index, and bus_wdata set to chain bits 33:2. A data-phase update that follows a read issues no request.
- R7: Once bus_req is raised, it stays high with bus_idx, bus_rd and bus_wdata unchanged until the rising edge that samples bus_ack high. busy equals bus_req.
- R8: An update is accepted, and toggles the phase, only if busy was clear at the preceding capture. Otherwise the phase is unchanged and no request is issued.
- R9: While sel is low, the strobes are ignored, no request is issued, and the phase returns to address, so the next selected access starts with an address scan.
- R10: An acknowledge with bus_err high sets the error flag. The flag stays set until the next accepted address-phase update clears it.
- R11: The read data returned with an acknowledge of a read is held and appears in bits 33:2 of the next capture.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| tck | input | 1 | Test clock; the whole block runs on it |
| rst | input | 1 | Synchronous active-high reset |
| sel | input | 1 | Instruction for this register is active |
| cap_dr | input | 1 | TAP in Capture-DR |
| shift_dr | input | 1 | TAP in Shift-DR |
| upd_dr | input | 1 | TAP in Update-DR |
| tdi | input | 1 | Serial data in |
| tdo | output | 1 | Serial data out, falling-edge timed |
| bus_idx | output | 7 | Debug register index |
| bus_rd | output | 1 | 1 = read, 0 = write |
| bus_wdata | output | 32 | Write data |
| bus_req | output | 1 | Access request, held until acknowledge |
| bus_rdata | input | 32 | Read data, valid with acknowledge |
| bus_ack | input | 1 | Access complete |
| bus_err | input | 1 | Access failed, valid with acknowledge |

## Verification
Several properties are checked on every cycle by the assertions:
- tdo tracks chain bit 0.
- The two status bits are placed correctly at capture.
- A request holds stable until its acknowledge.
- No access starts while busy is set.
- The phase freezes on a busy update and falls back to address while deselected.
- The error flag is sticky.

Other behaviour only the bench's scenarios can show, by comparing against a cycle model and by reading back over the scan path:
- The full alternating sequence, including 8-bit and 34-bit address scans.
- A write followed by a read-back of the same register.
- The retry after a busy scan.
- Clearing of the error on the next address.
- The restart in the address phase after deselection.

// File: rtl/dar_pkg.sv
package dar_pkg;

    localparam int DAR_IDX_W  = 7;
    localparam int DAR_DATA_W = 32;
    localparam int DAR_STAT_W = 2;

    typedef enum logic {
        PH_ADDR = 1'b0,
        PH_DATA = 1'b1
    } phase_e;

    typedef struct packed {
        logic err;
        logic busy;
    } stat_t;

    function automatic phase_e next_phase(input phase_e p);
        return (p == PH_ADDR) ? PH_DATA : PH_ADDR;
    endfunction

endpackage

// File: rtl/dar_scan_chain.sv
module dar_scan_chain #(
    parameter int CHAIN_W = dar_pkg::DAR_DATA_W + dar_pkg::DAR_STAT_W
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               shift_en,
    input  logic               cap_en,
    input  logic [CHAIN_W-1:0] cap_val,
    input  logic               tdi,
    output logic [CHAIN_W-1:0] sr,
    output logic               tdo
);

    always_ff @(posedge clk) begin
        if (rst) begin
            sr <= '0;
        end else if (shift_en) begin
            sr <= {tdi, sr[CHAIN_W-1:1]};
        end else if (cap_en) begin
            sr <= cap_val;
        end
    end

    always_ff @(negedge clk) begin
        if (rst) begin
            tdo <= 1'b0;
        end else begin
            tdo <= sr[0];
        end
    end

endmodule

// File: rtl/dar_phase_ctrl.sv
module dar_phase_ctrl
    import dar_pkg::*;
#(
    parameter int IDX_W   = DAR_IDX_W,
    parameter int DATA_W  = DAR_DATA_W,
    parameter int CHAIN_W = DATA_W + DAR_STAT_W
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               sel,
    input  logic               cap_en,
    input  logic               upd_en,
    input  logic               busy,
    input  logic [CHAIN_W-1:0] chain,
    output phase_e             phase,
    output logic               start_rd,
    output logic               start_wr,
    output logic               clr_err,
    output logic [IDX_W-1:0]   cmd_idx,
    output logic [DATA_W-1:0]  cmd_wdata
);

    localparam int DIR_BIT = CHAIN_W - 1;
    localparam int IDX_HI  = CHAIN_W - 2;
    localparam int IDX_LO  = CHAIN_W - 1 - IDX_W;

    logic             busy_snap;
    logic             dir_q;
    logic [IDX_W-1:0] idx_q;
    logic             accept;

    assign accept    = sel && upd_en && !busy_snap;
    assign start_rd  = accept && (phase == PH_ADDR) && chain[DIR_BIT];
    assign start_wr  = accept && (phase == PH_DATA) && !dir_q;
    assign clr_err   = accept && (phase == PH_ADDR);
    assign cmd_idx   = (phase == PH_ADDR) ? chain[IDX_HI:IDX_LO] : idx_q;
    assign cmd_wdata = chain[CHAIN_W-1:DAR_STAT_W];

    always_ff @(posedge clk) begin
        if (rst) begin
            phase     <= PH_ADDR;
            busy_snap <= 1'b0;
            dir_q     <= 1'b0;
            idx_q     <= '0;
        end else if (!sel) begin
            phase <= PH_ADDR;
        end else begin
            if (cap_en) begin
                busy_snap <= busy;
            end
            if (accept) begin
                phase <= next_phase(phase);
                if (phase == PH_ADDR) begin
                    dir_q <= chain[DIR_BIT];
                    idx_q <= chain[IDX_HI:IDX_LO];
                end
            end
        end
    end

    AST_BUSY_FREEZE: assert property (@(posedge clk) disable iff (rst)
        (sel && upd_en && busy_snap) |=> $stable(phase)); // R8
    AST_DESEL_ADDR: assert property (@(posedge clk) disable iff (rst)
        (!sel) |=> (phase == PH_ADDR)); // R9

endmodule

// File: rtl/dar_bus_master.sv
module dar_bus_master
    import dar_pkg::*;
#(
    parameter int IDX_W  = DAR_IDX_W,
    parameter int DATA_W = DAR_DATA_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              start_rd,
    input  logic              start_wr,
    input  logic              clr_err,
    input  logic [IDX_W-1:0]  cmd_idx,
    input  logic [DATA_W-1:0] cmd_wdata,
    input  logic              ack,
    input  logic              ack_err,
    input  logic [DATA_W-1:0] rdata_in,
    output logic              req,
    output logic              rd,
    output logic [IDX_W-1:0]  idx,
    output logic [DATA_W-1:0] wdata,
    output stat_t             stat,
    output logic [DATA_W-1:0] rdata
);

    logic err_q;

    assign stat.busy = req;
    assign stat.err  = err_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            req   <= 1'b0;
            rd    <= 1'b0;
            idx   <= '0;
            wdata <= '0;
            err_q <= 1'b0;
            rdata <= '0;
        end else begin
            if (req && ack) begin
                req <= 1'b0;
                if (rd) begin
                    rdata <= rdata_in;
                end
                if (ack_err) begin
                    err_q <= 1'b1;
                end
            end
            if (clr_err) begin
                err_q <= 1'b0;
            end
            if (start_rd) begin
                req <= 1'b1;
                rd  <= 1'b1;
                idx <= cmd_idx;
            end else if (start_wr) begin
                req   <= 1'b1;
                rd    <= 1'b0;
                idx   <= cmd_idx;
                wdata <= cmd_wdata;
            end
        end
    end

    AST_REQ_HOLD: assert property (@(posedge clk) disable iff (rst)
        (req && !ack) |=> (req && $stable(idx) && $stable(rd) && $stable(wdata))); // R7
    AST_NO_START_BUSY: assert property (@(posedge clk) disable iff (rst)
        (start_rd || start_wr) |-> !req); // R8
    AST_ERR_STICKY: assert property (@(posedge clk) disable iff (rst)
        (err_q && !clr_err) |=> err_q); // R10

endmodule

// File: rtl/jtag_alt_dr.sv
module jtag_alt_dr
    import dar_pkg::*;
#(
    parameter int IDX_W  = DAR_IDX_W,
    parameter int DATA_W = DAR_DATA_W
) (
    input  logic              tck,
    input  logic              rst,
    input  logic              sel,
    input  logic              cap_dr,
    input  logic              shift_dr,
    input  logic              upd_dr,
    input  logic              tdi,
    output logic              tdo,
    output logic [IDX_W-1:0]  bus_idx,
    output logic              bus_rd,
    output logic [DATA_W-1:0] bus_wdata,
    output logic              bus_req,
    input  logic [DATA_W-1:0] bus_rdata,
    input  logic              bus_ack,
    input  logic              bus_err
);

    localparam int CHAIN_W = DATA_W + DAR_STAT_W;

    logic [CHAIN_W-1:0] chain_sr;
    logic [CHAIN_W-1:0] cap_val;
    logic [DATA_W-1:0]  rdata_hold;
    logic [IDX_W-1:0]   cmd_idx;
    logic [DATA_W-1:0]  cmd_wdata;
    logic               start_rd;
    logic               start_wr;
    logic               clr_err;
    stat_t              stat;
    phase_e             phase;

    assign cap_val = {rdata_hold, stat};

    dar_scan_chain #(.CHAIN_W(CHAIN_W)) i_chain (
        .clk      (tck),
        .rst      (rst),
        .shift_en (sel && shift_dr),
        .cap_en   (sel && cap_dr),
        .cap_val  (cap_val),
        .tdi      (tdi),
        .sr       (chain_sr),
        .tdo      (tdo)
    );

    dar_phase_ctrl #(.IDX_W(IDX_W), .DATA_W(DATA_W), .CHAIN_W(CHAIN_W)) i_phase (
        .clk       (tck),
        .rst       (rst),
        .sel       (sel),
        .cap_en    (cap_dr),
        .upd_en    (upd_dr),
        .busy      (stat.busy),
        .chain     (chain_sr),
        .phase     (phase),
        .start_rd  (start_rd),
        .start_wr  (start_wr),
        .clr_err   (clr_err),
        .cmd_idx   (cmd_idx),
        .cmd_wdata (cmd_wdata)
    );

    dar_bus_master #(.IDX_W(IDX_W), .DATA_W(DATA_W)) i_bus (
        .clk       (tck),
        .rst       (rst),
        .start_rd  (start_rd),
        .start_wr  (start_wr),
        .clr_err   (clr_err),
        .cmd_idx   (cmd_idx),
        .cmd_wdata (cmd_wdata),
        .ack       (bus_ack),
        .ack_err   (bus_err),
        .rdata_in  (bus_rdata),
        .req       (bus_req),
        .rd        (bus_rd),
        .idx       (bus_idx),
        .wdata     (bus_wdata),
        .stat      (stat),
        .rdata     (rdata_hold)
    );

    AST_TDO_LSB: assert property (@(posedge tck) disable iff (rst)
        tdo == chain_sr[0]); // R2
    AST_CAP_STATUS: assert property (@(posedge tck) disable iff (rst)
        (sel && cap_dr && !shift_dr) |=> (chain_sr[1:0] == {$past(stat.err), $past(stat.busy)})); // R3

endmodule

// File: tb/test_jtag_alt_dr.sv
module test_jtag_alt_dr;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        sel = 1'b0, cap = 1'b0, sh = 1'b0, upd = 1'b0, tdi = 1'b0;
    logic        tdo;
    logic [6:0]  bus_idx;
    logic        bus_rd, bus_req;
    logic [31:0] bus_wdata;
    logic [31:0] bus_rdata = '0;
    logic        bus_ack = 1'b0, bus_err = 1'b0;

    int n_chk = 0;
    int n_fail = 0;
    int lat = 2;
    logic [31:0] mem [128];

    always #5 clk = ~clk;

    jtag_alt_dr i_jtag_alt_dr (
        .tck(clk), .rst(rst), .sel(sel), .cap_dr(cap), .shift_dr(sh), .upd_dr(upd),
        .tdi(tdi), .tdo(tdo), .bus_idx(bus_idx), .bus_rd(bus_rd), .bus_wdata(bus_wdata),
        .bus_req(bus_req), .bus_rdata(bus_rdata), .bus_ack(bus_ack), .bus_err(bus_err)
    );

    task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    // behavioural bus responder with a register bank
    initial begin
        for (int i = 0; i < 128; i++) mem[i] = 32'hA500_0000 ^ (i * 32'h0101_0101);
    end
    always begin
        int cnt;
        @(posedge clk); #2;
        if (bus_ack) begin
            bus_ack = 1'b0;
            bus_err = 1'b0;
            cnt = 0;
        end else if (bus_req) begin
            cnt++;
            if (cnt >= lat) begin
                bus_ack   = 1'b1;
                bus_err   = (bus_idx == 7'h7F);
                bus_rdata = mem[bus_idx];
                if (!bus_rd) mem[bus_idx] = bus_wdata;
                cnt = 0;
            end
        end else begin
            cnt = 0;
        end
    end

    // cycle reference model
    logic [33:0] m_sr;
    logic        m_req, m_rd, m_dir, m_err, m_snap, m_data_ph, m_live;
    logic [6:0]  m_idx;
    logic [31:0] m_wdata, m_rdata;

    always @(posedge clk) begin
        if (m_live) chk(tdo === m_sr[0], "R2 tdo", tdo, m_sr[0]);
        if (rst) begin
            m_sr = '0; m_req = 0; m_rd = 0; m_dir = 0; m_err = 0; m_snap = 0;
            m_data_ph = 0; m_live = 0; m_idx = '0; m_wdata = '0; m_rdata = '0;
        end else begin
            logic [33:0] old_sr;
            old_sr = m_sr;
            if (m_req && bus_ack) begin
                m_req = 0;
                if (m_rd) m_rdata = bus_rdata;
                if (bus_err) m_err = 1;
            end
            if (!sel) begin
                m_data_ph = 0;
            end else begin
                if (sh) m_sr = {tdi, m_sr[33:1]};
                else if (cap) begin
                    m_sr = {m_rdata, m_err, m_req};
                end
                if (cap) m_snap = m_req;
                if (upd && !m_snap) begin
                    if (!m_data_ph) begin
                        m_idx = old_sr[32:26];
                        m_dir = old_sr[33];
                        m_err = 0;
                        if (m_dir) begin m_req = 1; m_rd = 1; end
                    end else if (!m_dir) begin
                        m_req = 1; m_rd = 0; m_wdata = old_sr[33:2];
                    end
                    m_data_ph = !m_data_ph;
                end
            end
            m_live = 1;
        end
    end

    always @(negedge clk) begin
        if (m_live && !rst) begin
            chk(bus_req === m_req, "R7 bus_req", bus_req, m_req);
            if (m_req) begin
                chk(bus_idx === m_idx, "R5 bus_idx", bus_idx, m_idx);
                chk(bus_rd === m_rd, "R5 bus_rd", bus_rd, m_rd);
                if (!m_rd) chk(bus_wdata === m_wdata, "R6 bus_wdata", bus_wdata, m_wdata);
            end
        end
    end

    task automatic tick();
        @(posedge clk); #2;
    endtask

    task automatic scan(input logic [33:0] din, input int n, output logic [33:0] dout);
        dout = '0;
        cap = 1; tick(); cap = 0; sh = 1;
        for (int k = 0; k < n; k++) begin
            tdi = din[34-n+k];
            @(negedge clk); #1;
            dout[k] = tdo;
            tick();
        end
        sh = 0; tdi = 0; tick();
        upd = 1; tick(); upd = 0; tick();
    endtask

    function automatic logic [33:0] afield(input logic dir, input logic [6:0] ix);
        return {dir, ix, 26'b0};
    endfunction

    bit done = 0;
    initial begin
        #2_000_000;
        if (!done) begin
            n_chk++; n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        logic [33:0] d;
        logic [31:0] wv;
        repeat (3) tick();
        rst = 0;
        tick();
        chk(bus_req === 1'b0, "R1 req after reset", bus_req, 0);
        chk(tdo === 1'b0, "R1 tdo after reset", tdo, 0);
        sel = 1; tick();

        // R4/R6: 8-bit address scan for write to index 5, then data scan
        wv = 32'hDEAD_BEEF;
        scan(afield(1'b0, 7'd5), 8, d);
        chk(d[1:0] === 2'b00, "R1 R3 status at first capture", d[1:0], 0);
        chk(bus_req === 1'b0, "R6 no request on write address", bus_req, 0);
        scan({wv, 2'b00}, 34, d);
        repeat (10) tick();
        chk(mem[5] === wv, "R6 write reached register", mem[5], wv);

        // R5/R11: read back index 5 using a 34-bit address scan (R4)
        scan(afield(1'b1, 7'd5) | 34'h155_5555, 34, d);
        repeat (10) tick();
        scan('0, 34, d);
        chk(d[33:2] === wv, "R11 R5 read data", d[33:2], wv);
        chk(d[0] === 1'b0, "R3 busy clear", d[0], 0);

        // R8: busy scan repeats the data phase
        lat = 60;
        scan(afield(1'b1, 7'd20), 8, d);
        scan('0, 34, d);
        chk(d[0] === 1'b1, "R8 busy seen at capture", d[0], 1);
        repeat (80) tick();
        scan('0, 34, d);
        chk(d[0] === 1'b0, "R8 busy clear on retry", d[0], 0);
        chk(d[33:2] === mem[20], "R8 R11 retry returns data", d[33:2], mem[20]);
        chk(bus_req === 1'b0, "R8 no extra request", bus_req, 0);

        // R10: error latch and clear
        lat = 2;
        scan(afield(1'b1, 7'h7F), 8, d);
        repeat (6) tick();
        scan('0, 34, d);
        chk(d[1] === 1'b1, "R10 error captured", d[1], 1);
        scan(afield(1'b0, 7'd3), 8, d);
        chk(d[1] === 1'b1, "R10 error still set before new address", d[1], 1);
        scan({32'h1234_5678, 2'b00}, 34, d);
        chk(d[1] === 1'b0, "R10 error cleared by address phase", d[1], 0);
        repeat (6) tick();
        chk(mem[3] === 32'h1234_5678, "R6 second write", mem[3], 32'h1234_5678);

        // R9: deselect mid-access resets to address phase
        scan(afield(1'b0, 7'd4), 8, d);
        sel = 0; tick();
        scan(afield(1'b1, 7'd1), 8, d);
        chk(bus_req === 1'b0, "R9 no request while deselected", bus_req, 0);
        sel = 1; tick();
        lat = 10;
        scan(afield(1'b1, 7'd9), 8, d);
        chk(bus_req === 1'b1 && bus_rd === 1'b1 && bus_idx === 7'd9,
            "R9 address phase after reselect", {bus_req, bus_rd, bus_idx}, {2'b11, 7'd9});
        repeat (15) tick();
        scan('0, 34, d);
        chk(d[33:2] === mem[9], "R9 R11 reselect read data", d[33:2], mem[9]);
        chk(mem[4] === (32'hA500_0000 ^ (4 * 32'h0101_0101)), "R9 abandoned write not issued",
            mem[4], 32'hA500_0000 ^ (4 * 32'h0101_0101));

        repeat (4) tick();
        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

endmodule